// File: doc/BRIEF.md
# Line-Addressed Serial Read Port

This block is the read side of a field memory that is organised in lines. Before a line is read, its line number is shifted in one bit per read clock while an address-enable input is held high. When address-enable drops, the shifted number becomes the current line and the column pointer returns to zero. Reads then stream words from that line, one per read clock. A read enable decides whether the column pointer moves. A separate output enable decides whether the data pins are driven or left floating.

The column pointer stops at the last word of a line and does not wrap. Reading the next line needs a new address-setting window, or a one-cycle reset-mode cycle that jumps to line 0, column 0. A read request on an edge where reading is not allowed is refused and reported on an error output. This covers the edge on which the address window closes, any edge inside the window, a reset-mode cycle, and any edge before the first line has been selected. The block holds a small behavioural storage array that is filled with a computed pattern at reset, so it can be checked on its own.

Top module: `line_serial_rd`

## Requirements
- R1: While `addrEn` is high, each rising clock shifts `serAddr` into a 9-bit line register, with the first bit sent becoming the most significant bit. At the first rising edge with `addrEn` low, the last nine bits shifted in become the line and the column pointer becomes 0.
- R2: On an edge with `addrEn` high, the column pointer does not change and `dataDrv` is low after that edge.
- R3: On a permitted edge with `readEn` high, the column pointer advances by one. After the edge, `dataOut` shows the word at the pointer value from before the edge.
- R4: `dataDrv` goes high after a permitted edge with `outEn` high, and low otherwise. When it is low, `dataOut` is high impedance. The pointer still advances with `readEn` high and `outEn` low.
- R5: On a permitted edge with `readEn` low, the pointer holds, so the same word is presented again.
- R6: At column `WORDS-1`, further reads leave the pointer at `WORDS-1`.
- R7: An edge with `rstMode` high and `addrEn` low sets the line to 0 and the column to 0. A read on that edge is refused, and the next edge is permitted. If that edge is also the first edge after the address window closes, the shifted line is loaded instead.
- R8: The first edge after the address window closes refuses reads, and the edge after it is permitted. Until a line has been selected after `rstN`, every edge refuses reads.
- R9: `rdErr` is high for one cycle after every edge on which `readEn` was high and the read was refused. Refused edges never drive the output.
- R10: The word at line L, column C equals `((L mod 2^SEL_W)*WORDS + C)*5 + 3`, truncated to `DW` bits.
- R11: While `rstN` is low, `rdErr` and `dataDrv` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rclk | input | 1 | Read clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| addrEn | input | 1 | Address-setting window enable |
| serAddr | input | 1 | Serial line-address bit |
| rstMode | input | 1 | Address-reset cycle request |
| readEn | input | 1 | Advance the column pointer |
| outEn | input | 1 | Drive the data output |
| dataOut | output | DW | Registered read word, high impedance when not driven |
| dataDrv | output | 1 | High while `dataOut` is driven |
| rdErr | output | 1 | A refused read happened on the previous edge |

## Verification
The assertions assume that every control input is synchronous to `rclk`, is stable around its rising edge, and is never unknown after reset. They also assume that `rstMode` and a closing address window may coincide, but that nothing else overrides the window. The bench changes all inputs only on the falling clock edge. It covers every combination of read enable and output enable, windows with more than nine address bits, reset cycles inside and at the end of a window, and reads that run past the end of a line.

// File: rtl/lsrp_pkg.sv
package lsrp_pkg;

  // Per-edge strobes from control to datapath
  typedef struct packed {
    logic shiftIn;   // shift one address bit
    logic loadLine;  // take shifted line, clear column
    logic zeroLine;  // reset cycle: line 0, column 0
    logic advance;   // step the column pointer
    logic capture;   // register the addressed word
    logic drive;     // drive output after this edge
  } rdStrobe_t;

endpackage

// File: rtl/lsrp_store.sv
module lsrp_store #(
  parameter int WORDS = 960,
  parameter int DW    = 12,
  parameter int SEL_W = 1,
  localparam int COL_W = $clog2(WORDS),
  localparam int LINES = 1 << SEL_W,
  localparam int DEPTH = LINES * WORDS,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selLine,
  input  logic [COL_W-1:0] col,
  output logic [DW-1:0]    word
);

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] idx;

  // Contents are a computed pattern, filled at reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= DW'(i * 5 + 3);
      end
    end
  end

  always_comb begin
    idx  = IDX_W'(selLine) * IDX_W'(WORDS) + IDX_W'(col);
    word = mem[idx];
  end

endmodule

// File: rtl/lsrp_ctrl.sv
module lsrp_ctrl
  import lsrp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      addrEn,
  input  logic      rstMode,
  input  logic      readEn,
  input  logic      outEn,
  output rdStrobe_t strb,
  output logic      rdErr
);

  logic addrEnQ;
  logic ready;
  logic fallEdge;
  logic permit;

  always_comb begin
    fallEdge      = addrEnQ && !addrEn;
    permit        = ready && !addrEn && !rstMode;
    strb.shiftIn  = addrEn;
    strb.loadLine = fallEdge;
    strb.zeroLine = !addrEn && !fallEdge && rstMode;
    strb.advance  = permit && readEn;
    strb.capture  = permit;
    strb.drive    = permit && outEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrEnQ <= 1'b0;
      ready   <= 1'b0;
      rdErr   <= 1'b0;
    end else begin
      addrEnQ <= addrEn;
      rdErr   <= readEn && !permit;
      if (addrEn) begin
        ready <= 1'b0;
      end else if (fallEdge || rstMode) begin
        ready <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lsrp_path.sv
module lsrp_path
  import lsrp_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int WORDS  = 960,
  parameter int DW     = 12,
  parameter int SEL_W  = 1,
  localparam int COL_W = $clog2(WORDS),
  localparam logic [COL_W-1:0] LAST = COL_W'(WORDS - 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serAddr,
  input  rdStrobe_t        strb,
  output logic [DW-1:0]    dataQ,
  output logic             drvQ,
  output logic [COL_W-1:0] colPtr
);

  logic [LINE_W-1:0] shiftQ;
  logic [LINE_W-1:0] lineQ;
  logic [COL_W-1:0]  colQ;
  logic [DW-1:0]     rdWord;
  logic              unusedLineHi;

  assign unusedLineHi = ^lineQ[LINE_W-1:SEL_W];
  assign colPtr       = colQ;

  lsrp_store #(
    .WORDS (WORDS),
    .DW    (DW),
    .SEL_W (SEL_W)
  ) store_i (
    .clk     (clk),
    .rstN    (rstN),
    .selLine (lineQ[SEL_W-1:0]),
    .col     (colQ),
    .word    (rdWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      lineQ  <= '0;
      colQ   <= '0;
      dataQ  <= '0;
      drvQ   <= 1'b0;
    end else begin
      if (strb.shiftIn) begin
        shiftQ <= {shiftQ[LINE_W-2:0], serAddr};
      end
      if (strb.loadLine) begin
        lineQ <= shiftQ;
        colQ  <= '0;
      end else if (strb.zeroLine) begin
        lineQ <= '0;
        colQ  <= '0;
      end else if (strb.advance && colQ != LAST) begin
        colQ <= colQ + 1'b1;
      end
      if (strb.capture) begin
        dataQ <= rdWord;
      end
      drvQ <= strb.drive;
    end
  end

endmodule

// File: rtl/line_serial_rd.sv
module line_serial_rd
  import lsrp_pkg::*;
#(
  parameter int LINE_W = 9,
  parameter int WORDS  = 960,
  parameter int DW     = 12,
  parameter int SEL_W  = 1,
  localparam int COL_W = $clog2(WORDS)
) (
  input  logic          rclk,
  input  logic          rstN,
  input  logic          addrEn,
  input  logic          serAddr,
  input  logic          rstMode,
  input  logic          readEn,
  input  logic          outEn,
  output logic [DW-1:0] dataOut,
  output logic          dataDrv,
  output logic          rdErr
);

  rdStrobe_t        strb;
  logic [DW-1:0]    dataQ;
  logic [COL_W-1:0] colPtr;

  lsrp_ctrl ctrl_i (
    .clk     (rclk),
    .rstN    (rstN),
    .addrEn  (addrEn),
    .rstMode (rstMode),
    .readEn  (readEn),
    .outEn   (outEn),
    .strb    (strb),
    .rdErr   (rdErr)
  );

  lsrp_path #(
    .LINE_W (LINE_W),
    .WORDS  (WORDS),
    .DW     (DW),
    .SEL_W  (SEL_W)
  ) path_i (
    .clk     (rclk),
    .rstN    (rstN),
    .serAddr (serAddr),
    .strb    (strb),
    .dataQ   (dataQ),
    .drvQ    (dataDrv),
    .colPtr  (colPtr)
  );

  assign dataOut = dataDrv ? dataQ : 'z;

endmodule

// File: rtl/lsrp_chk.sv
module lsrp_chk #(
  parameter int WORDS = 960,
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             addrEn,
  input logic             rstMode,
  input logic             readEn,
  input logic             outEn,
  input logic             dataDrv,
  input logic             rdErr,
  input logic [COL_W-1:0] colPtr
);

  localparam logic [COL_W-1:0] LAST = COL_W'(WORDS - 1);

  // R2
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrEn |=> $stable(colPtr));

  // R2
  win_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrEn |=> !dataDrv);

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrEn && !rstMode && !$fell(addrEn)) |=>
      (colPtr == $past(colPtr) || colPtr == $past(colPtr) + 1'b1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!readEn && !addrEn && !rstMode && !$fell(addrEn)) |=> $stable(colPtr));

  // R6
  line_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (colPtr == LAST) |=> (colPtr == LAST || colPtr == '0));

  // R4
  drive_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataDrv |-> $past(outEn));

  // R7
  reset_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstMode |=> !dataDrv);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> ($past(readEn) && !dataDrv));

endmodule

bind line_serial_rd lsrp_chk #(
  .WORDS (WORDS),
  .COL_W (COL_W)
) chk_i (
  .clk     (rclk),
  .rstN    (rstN),
  .addrEn  (addrEn),
  .rstMode (rstMode),
  .readEn  (readEn),
  .outEn   (outEn),
  .dataDrv (dataDrv),
  .rdErr   (rdErr),
  .colPtr  (colPtr)
);

// File: tb/line_serial_rd_tb_top.sv
`timescale 1ns/1ps
module line_serial_rd_tb_top;

  localparam int LINE_W = 9;
  localparam int WORDS  = 960;
  localparam int DW     = 12;
  localparam int SEL_W  = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrEn = 1'b0, serAddr = 1'b0, rstMode = 1'b0;
  logic readEn = 1'b0, outEn = 1'b0;
  wire [DW-1:0] dataOut;
  wire dataDrv, rdErr;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  line_serial_rd #(.LINE_W(LINE_W), .WORDS(WORDS), .DW(DW), .SEL_W(SEL_W)) dut_i (
    .rclk(clk), .rstN(rstN), .addrEn(addrEn), .serAddr(serAddr), .rstMode(rstMode),
    .readEn(readEn), .outEn(outEn), .dataOut(dataOut), .dataDrv(dataDrv), .rdErr(rdErr));

  // R10 content formula
  function automatic int wordOf(int line, int col);
    return (((line % (1 << SEL_W)) * WORDS + col) * 5 + 3) % (1 << DW);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mShift, mLine, mCol, mData;
  bit mReady, mPrev, mDrv, mErr;
  always @(posedge clk) begin
    if (!rstN) begin
      mShift = 0; mLine = 0; mCol = 0; mData = 0;
      mReady = 0; mPrev = 0; mDrv = 0; mErr = 0;
    end else begin
      bit fall, permit;
      fall   = mPrev && !addrEn;
      permit = mReady && !addrEn && !rstMode;
      mErr   = readEn && !permit;
      mDrv   = outEn && permit;
      if (permit) mData = wordOf(mLine, mCol);
      if (addrEn) begin
        mShift = ((mShift << 1) | int'(serAddr)) & ((1 << LINE_W) - 1);
        mReady = 0;
      end else if (fall) begin
        mLine = mShift; mCol = 0; mReady = 1;
      end else if (rstMode) begin
        mLine = 0; mCol = 0; mReady = 1;
      end else if (permit && readEn && mCol < WORDS - 1) begin
        mCol++;
      end
      mPrev = addrEn;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(dataDrv == mDrv, "R4 drive", int'(dataDrv), int'(mDrv));
      chk(rdErr == mErr, "R9 error", int'(rdErr), int'(mErr));
      if (mDrv) chk(int'(dataOut) == mData, "R3 data", int'(dataOut), mData);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic setLine(int addr, int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      addrEn = 1'b1;
      serAddr = 1'((addr >> i) & 1);
      step();
    end
    addrEn = 1'b0;
    serAddr = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    // R11
    chk(rdErr == 1'b0, "R11 err", int'(rdErr), 0);
    chk(dataDrv == 1'b0, "R11 drv", int'(dataDrv), 0);
    rstN = 1'b1;
    step();

    // R8 no line selected yet
    readEn = 1'b1; step();
    chk(rdErr == 1'b1, "R8 unaddressed", int'(rdErr), 1);
    readEn = 1'b0; step();

    // R1 / R8 / R3
    setLine(5, 9);
    readEn = 1'b1; outEn = 1'b1; step();
    chk(rdErr == 1'b1, "R8 close edge", int'(rdErr), 1);
    step();
    chk(int'(dataOut) == wordOf(5, 0), "R1 first word", int'(dataOut), wordOf(5, 0));
    chk(int'(dataOut) == 5 * WORDS % 4096 * 0 + wordOf(1, 0), "R10 pattern", int'(dataOut), wordOf(1, 0));
    repeat (2) step();
    chk(int'(dataOut) == wordOf(5, 2), "R3 stream", int'(dataOut), wordOf(5, 2));

    // R4 advance while floating
    outEn = 1'b0; repeat (4) step();
    chk(dataDrv == 1'b0, "R4 float", int'(dataDrv), 0);
    readEn = 1'b0; outEn = 1'b1; step();
    chk(int'(dataOut) == wordOf(5, 7), "R4 advanced", int'(dataOut), wordOf(5, 7));
    step();
    chk(int'(dataOut) == wordOf(5, 7), "R5 hold", int'(dataOut), wordOf(5, 7));

    // R2 reads inside the window
    readEn = 1'b1;
    setLine(3, 9);
    chk(rdErr == 1'b1, "R2 window err", int'(rdErr), 1);
    chk(dataDrv == 1'b0, "R2 window drv", int'(dataDrv), 0);
    readEn = 1'b0; step();
    readEn = 1'b1; step();
    chk(int'(dataOut) == wordOf(3, 0), "R2 reload", int'(dataOut), wordOf(3, 0));

    // R1 extra bits: last nine win (1030 -> 6)
    readEn = 1'b0;
    setLine(1030, 11);
    step();
    readEn = 1'b1; step();
    chk(int'(dataOut) == wordOf(6, 0), "R1 last nine", int'(dataOut), wordOf(6, 0));
    repeat (2) step();

    // R7 reset cycle
    rstMode = 1'b1; step();
    chk(rdErr == 1'b1, "R7 reset refuse", int'(rdErr), 1);
    rstMode = 1'b0; step();
    chk(int'(dataOut) == wordOf(0, 0), "R7 reset line", int'(dataOut), wordOf(0, 0));
    chk(rdErr == 1'b0, "R9 pulse ends", int'(rdErr), 0);

    // R7 load wins over reset at window close
    readEn = 1'b0; rstMode = 1'b1;
    setLine(7, 9);
    step();
    rstMode = 1'b0; readEn = 1'b1; step();
    chk(int'(dataOut) == wordOf(7, 0), "R7 load wins", int'(dataOut), wordOf(7, 0));

    // R6 saturation
    readEn = 1'b0;
    setLine(2, 9);
    step();
    readEn = 1'b1;
    repeat (WORDS + 4) step();
    chk(int'(dataOut) == wordOf(2, WORDS - 1), "R6 saturate", int'(dataOut), wordOf(2, WORDS - 1));
    readEn = 1'b0; step();
    chk(int'(dataOut) == wordOf(2, WORDS - 1), "R6 stays", int'(dataOut), wordOf(2, WORDS - 1));

    step();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule